// File: doc/BRIEF.md
# SD Host Interrupt Status Controller

This block gathers the event pulses of an SD/MMC host into two byte-wide status registers. Bits are sticky, and software clears them by writing ones. Two byte-wide enable registers mask the status bits. A global enable bit, held in a separate configuration register, gates the result before it drives one level-sensitive interrupt line to the CPU. The command engine and the data engine report completions and errors as single-cycle pulses. Card presence comes from one of two card-detect pins, or from both. These pins pass through a synchronizer and a selectable polarity stage, and every change of the selected presence level raises its own status bits.

Software reaches the block through a byte-addressed port. Writes are synchronous and reads are combinational. Register offsets: 0 status-0, 1 status-1, 2 enable-0, 3 enable-1, 4 configuration, 5 mode. Any other offset reads as zero.

Top module: `sdh_irq_ctrl`

## Requirements
- R1: After reset, all sticky status bits, both enable registers, the configuration register and the mode register read 0, and `irq_o` is low.
- R2: A pulse on `cmd_evt_i[n]` sets status-1 bit n. The bits are: 0 SDIO interrupt, 1 command done, 2 response timeout, 3 auto-stop done, 4 data timeout, 5 response CRC error, 6 read CRC error, 7 write CRC error. A pulse on `dat_evt_i[1]` sets status-0 bit 4 (multi-block done), and `dat_evt_i[0]` sets status-0 bit 5 (block done). Every such bit stays set until it is cleared.
- R3: Writing to a status register clears each sticky bit whose write-data bit is 1 and leaves the bits whose write-data bit is 0 unchanged. Writing 0xFF clears every sticky bit of that register.
- R4: When an event pulse and a write-one clear reach the same bit in the same cycle, the bit ends up set.
- R5: In enable-0 only bits 7..4 are writable, and bits 3..0 read 0. In enable-1 only bits 7..1 are writable, and bit 0 reads 0. Each enable bit sits at the same position as the status bit it gates.
- R6: `irq_o` is high exactly when configuration bit 7 is 1 and at least one status bit is 1 together with its enable bit. Because it has no enable bit, the SDIO status bit alone never raises `irq_o`.
- R7: With configuration bit 7 at 0, `irq_o` stays low whatever the status and enable registers hold.
- R8: Configuration bit 4 = 1 means a high pin level means card present, and 0 means a low level means present. Bit 6 selects the DATA3 pin (`cd_dat3_i`) and bit 5 selects the dedicated pin (`cd_gpi_i`). The selected presence is the OR of the selected sources. A change of that presence sets status-0 bit 6 on the third rising clock edge after the pin change, and a change to present also sets status-0 bit 7.
- R9: Status-0 bit 1 shows the synchronized `wp_i` level. Bit 2 shows DATA3 presence and bit 3 shows dedicated-pin presence, both polarity corrected and both live regardless of selection. Writes have no effect on these three bits.
- R10: Writing 1 to mode bit 7 clears every sticky status bit and both enable registers, even against an event pulse in the same cycle. The configuration register is kept, and the mode bit reads 0.
- R11: A change on a card-detect pin whose source is not selected sets neither status-0 bit 6 nor bit 7.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| reg_addr_i | input | ADDR_W | Register byte offset |
| reg_wr_i | input | 1 | Write strobe, sampled on the rising edge |
| reg_wdata_i | input | 8 | Write data |
| reg_rdata_o | output | 8 | Read data for `reg_addr_i` (combinational) |
| dat_evt_i | input | 2 | Data engine pulses: bit 0 block done, bit 1 multi-block done |
| cmd_evt_i | input | 8 | Command engine pulses, one per status-1 bit |
| cd_gpi_i | input | 1 | Dedicated card-detect pin (asynchronous) |
| cd_dat3_i | input | 1 | DATA3 card-detect level (asynchronous) |
| wp_i | input | 1 | Write-protect switch level (asynchronous) |
| irq_o | output | 1 | Level interrupt to the CPU |

## Verification
The status logic is driven with single event pulses on each bit position, so that a swapped or missing bit shows up as a wrong byte. It is also driven with clear patterns of 0x00, a partial mask and 0xFF, which separate write-one-clear from plain writes. A pulse landing in the same cycle as a clear of the same bit, and of a different bit, shows whether set has priority over clear. The interrupt is tried with the global enable both off and on, with matched and mismatched status and enable bits, and with a lone SDIO bit. Card detect is exercised by inserting and removing a card on the selected pin, which checks the three-edge latency, by toggling the unselected pin, and by flipping polarity.

// File: rtl/sdh_irq_pkg.sv
// Package: register offsets and bit positions shared by the interrupt
// status controller and its bench-facing documentation.
package sdh_irq_pkg;
    localparam int REG_W       = 8;
    localparam int OFS_STAT0   = 0;
    localparam int OFS_STAT1   = 1;
    localparam int OFS_EN0     = 2;
    localparam int OFS_EN1     = 3;
    localparam int OFS_CFG     = 4;
    localparam int OFS_MODE    = 5;

    // configuration register bit positions
    localparam int CFG_GIE     = 7;
    localparam int CFG_SEL_D3  = 6;
    localparam int CFG_SEL_GPI = 5;
    localparam int CFG_POL_HI  = 4;
    // mode register
    localparam int MODE_SRST   = 7;

    // writable enable bits
    localparam logic [REG_W-1:0] EN0_MASK = 8'hF0;
    localparam logic [REG_W-1:0] EN1_MASK = 8'hFE;
endpackage

// File: rtl/sdh_sync.sv
// Module: sdh_sync
// Multi-stage synchronizer for W asynchronous level inputs.
// Assumes STAGES >= 2; the flops reset to RST_VAL (idle pin level).
module sdh_sync #(
    parameter int              W       = 1,
    parameter int              STAGES  = 2,
    parameter logic [W-1:0]    RST_VAL = '1
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d_i,
    output logic [W-1:0] q_o
);
    logic [STAGES-1:0][W-1:0] pipe;

    // shift the asynchronous level through the stage chain
    always_ff @(posedge clk) begin
        if (!rst_n) pipe <= {STAGES{RST_VAL}};
        else        pipe <= {pipe[STAGES-2:0], d_i};
    end

    assign q_o = pipe[STAGES-1];
endmodule

// File: rtl/sdh_cd_detect.sv
// Module: sdh_cd_detect
// Applies polarity to the synchronized card-detect levels, combines the
// selected sources and emits one-cycle change / insert pulses.
// Assumes inputs are already synchronous to clk.
module sdh_cd_detect (
    input  logic clk,
    input  logic rst_n,
    input  logic gpi_s_i,
    input  logic dat3_s_i,
    input  logic pol_hi_i,
    input  logic sel_gpi_i,
    input  logic sel_dat3_i,
    output logic gpi_pres_o,
    output logic dat3_pres_o,
    output logic chg_o,
    output logic ins_o
);
    logic pres_sel;
    logic pres_prev;

    // polarity correction and source selection
    always_comb begin
        gpi_pres_o  = gpi_s_i  ~^ pol_hi_i;
        dat3_pres_o = dat3_s_i ~^ pol_hi_i;
        pres_sel    = (sel_gpi_i & gpi_pres_o) | (sel_dat3_i & dat3_pres_o);
    end

    // remember the previous selected presence level
    always_ff @(posedge clk) begin
        if (!rst_n) pres_prev <= 1'b0;
        else        pres_prev <= pres_sel;
    end

    assign chg_o = pres_sel ^ pres_prev;
    assign ins_o = pres_sel & ~pres_prev;

    p_insert_is_change_r8: assert property (@(posedge clk) disable iff (!rst_n)
        ins_o |-> chg_o);
endmodule

// File: rtl/sdh_stat_byte.sv
// Module: sdh_stat_byte
// W sticky status bits: set by event pulse, cleared by write-one,
// cleared by soft reset. Set beats write-one-clear; soft reset beats set.
module sdh_stat_byte #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         srst_i,
    input  logic         wr_i,
    input  logic [W-1:0] wdata_i,
    input  logic [W-1:0] set_i,
    output logic [W-1:0] q_o
);
    for (genvar i = 0; i < W; i++) begin : g_bit
        // one sticky bit with set priority over clear
        always_ff @(posedge clk) begin
            if (!rst_n || srst_i)         q_o[i] <= 1'b0;
            else if (set_i[i])            q_o[i] <= 1'b1;
            else if (wr_i && wdata_i[i])  q_o[i] <= 1'b0;
        end

        p_event_wins_r4: assert property (@(posedge clk) disable iff (!rst_n)
            (set_i[i] && !srst_i) |=> q_o[i]);
        p_w1c_clears_r3: assert property (@(posedge clk) disable iff (!rst_n)
            (wr_i && wdata_i[i] && !set_i[i]) |=> !q_o[i]);
        p_sticky_holds_r2: assert property (@(posedge clk) disable iff (!rst_n)
            (q_o[i] && !(wr_i && wdata_i[i]) && !srst_i) |=> q_o[i]);
    end
endmodule

// File: rtl/sdh_irq_ctrl.sv
// Module: sdh_irq_ctrl
// Interrupt status controller of an SD/MMC host: two sticky W1C status
// bytes, two enable bytes, a configuration byte (global enable, card
// detect source and polarity) and a self-clearing soft reset bit.
// Assumes event pulses are one cycle wide and synchronous to clk.
module sdh_irq_ctrl
    import sdh_irq_pkg::*;
#(
    parameter int ADDR_W      = 3,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] reg_addr_i,
    input  logic              reg_wr_i,
    input  logic [7:0]        reg_wdata_i,
    output logic [7:0]        reg_rdata_o,
    input  logic [1:0]        dat_evt_i,
    input  logic [7:0]        cmd_evt_i,
    input  logic              cd_gpi_i,
    input  logic              cd_dat3_i,
    input  logic              wp_i,
    output logic              irq_o
);
    localparam int STICKY0_W = 4;

    logic [7:0]           en0_q, en1_q;
    logic [3:0]           cfg_q;          // configuration bits 7..4
    logic [STICKY0_W-1:0] st0_sticky;
    logic [7:0]           st1_q;
    logic [7:0]           stat0;
    logic [2:0]           pins_s;
    logic                 gpi_pres, dat3_pres, cd_chg, cd_ins;
    logic                 srst, wr_st0, wr_st1, wr_en0, wr_en1, wr_cfg;
    logic                 cfg_gie;

    // decode register writes
    always_comb begin
        wr_st0  = reg_wr_i && (reg_addr_i == ADDR_W'(OFS_STAT0));
        wr_st1  = reg_wr_i && (reg_addr_i == ADDR_W'(OFS_STAT1));
        wr_en0  = reg_wr_i && (reg_addr_i == ADDR_W'(OFS_EN0));
        wr_en1  = reg_wr_i && (reg_addr_i == ADDR_W'(OFS_EN1));
        wr_cfg  = reg_wr_i && (reg_addr_i == ADDR_W'(OFS_CFG));
        srst    = reg_wr_i && (reg_addr_i == ADDR_W'(OFS_MODE))
                  && reg_wdata_i[MODE_SRST];
        cfg_gie = cfg_q[CFG_GIE-4];
    end

    // synchronize write-protect and both card-detect pins
    sdh_sync #(.W(3), .STAGES(SYNC_STAGES), .RST_VAL(3'b111)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d_i   ({wp_i, cd_dat3_i, cd_gpi_i}),
        .q_o   (pins_s)
    );

    sdh_cd_detect u_cd (
        .clk         (clk),
        .rst_n       (rst_n),
        .gpi_s_i     (pins_s[0]),
        .dat3_s_i    (pins_s[1]),
        .pol_hi_i    (cfg_q[CFG_POL_HI-4]),
        .sel_gpi_i   (cfg_q[CFG_SEL_GPI-4]),
        .sel_dat3_i  (cfg_q[CFG_SEL_D3-4]),
        .gpi_pres_o  (gpi_pres),
        .dat3_pres_o (dat3_pres),
        .chg_o       (cd_chg),
        .ins_o       (cd_ins)
    );

    // status-0 sticky bits 7..4: insert, change, block done, multi-block done
    sdh_stat_byte #(.W(STICKY0_W)) u_st0 (
        .clk     (clk),
        .rst_n   (rst_n),
        .srst_i  (srst),
        .wr_i    (wr_st0),
        .wdata_i (reg_wdata_i[7:4]),
        .set_i   ({cd_ins, cd_chg, dat_evt_i[0], dat_evt_i[1]}),
        .q_o     (st0_sticky)
    );

    // status-1: one sticky bit per command engine event
    sdh_stat_byte #(.W(8)) u_st1 (
        .clk     (clk),
        .rst_n   (rst_n),
        .srst_i  (srst),
        .wr_i    (wr_st1),
        .wdata_i (reg_wdata_i),
        .set_i   (cmd_evt_i),
        .q_o     (st1_q)
    );

    assign stat0 = {st0_sticky, gpi_pres, dat3_pres, pins_s[2], 1'b0};

    // enable registers, cleared by soft reset
    always_ff @(posedge clk) begin
        if (!rst_n || srst) begin
            en0_q <= '0;
            en1_q <= '0;
        end else begin
            if (wr_en0) en0_q <= reg_wdata_i & EN0_MASK;
            if (wr_en1) en1_q <= reg_wdata_i & EN1_MASK;
        end
    end

    // configuration register, kept across soft reset
    always_ff @(posedge clk) begin
        if (!rst_n)      cfg_q <= '0;
        else if (wr_cfg) cfg_q <= reg_wdata_i[7:4];
    end

    // register read multiplexer
    always_comb begin
        case (reg_addr_i)
            ADDR_W'(OFS_STAT0): reg_rdata_o = stat0;
            ADDR_W'(OFS_STAT1): reg_rdata_o = st1_q;
            ADDR_W'(OFS_EN0):   reg_rdata_o = en0_q;
            ADDR_W'(OFS_EN1):   reg_rdata_o = en1_q;
            ADDR_W'(OFS_CFG):   reg_rdata_o = {cfg_q, 4'h0};
            default:            reg_rdata_o = 8'h00;
        endcase
    end

    // masked and globally gated interrupt level
    assign irq_o = cfg_gie && (|(stat0 & en0_q) || |(st1_q & en1_q));

    p_gie_off_quiet_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !cfg_gie |-> !irq_o);
    p_sdio_alone_quiet_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (st1_q == 8'h01 && st0_sticky == '0) |-> !irq_o);
    p_srst_clears_en_r10: assert property (@(posedge clk) disable iff (!rst_n)
        srst |=> (en0_q == 8'h00 && en1_q == 8'h00 && st1_q == 8'h00));
endmodule

// File: tb/sdh_irq_ctrl_tb.sv
module sdh_irq_ctrl_tb;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [2:0] reg_addr_i = '0;
    logic       reg_wr_i = 1'b0;
    logic [7:0] reg_wdata_i = '0;
    logic [7:0] reg_rdata_o;
    logic [1:0] dat_evt_i = '0;
    logic [7:0] cmd_evt_i = '0;
    logic       cd_gpi_i = 1'b1;
    logic       cd_dat3_i = 1'b1;
    logic       wp_i = 1'b0;
    logic       irq_o;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;   // 250 MHz

    sdh_irq_ctrl u_dut (
        .clk(clk), .rst_n(rst_n), .reg_addr_i(reg_addr_i), .reg_wr_i(reg_wr_i),
        .reg_wdata_i(reg_wdata_i), .reg_rdata_o(reg_rdata_o),
        .dat_evt_i(dat_evt_i), .cmd_evt_i(cmd_evt_i), .cd_gpi_i(cd_gpi_i),
        .cd_dat3_i(cd_dat3_i), .wp_i(wp_i), .irq_o(irq_o)
    );

    task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual 0x%02h expected 0x%02h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [2:0] a, input logic [7:0] d);
        @(negedge clk);
        reg_addr_i = a; reg_wdata_i = d; reg_wr_i = 1'b1;
        @(negedge clk);
        reg_wr_i = 1'b0;
    endtask

    task automatic rd_check(input string tag, input logic [2:0] a, input logic [7:0] exp);
        reg_addr_i = a;
        #1;
        check(tag, reg_rdata_o, exp);
    endtask

    task automatic pulse(input logic [1:0] d, input logic [7:0] c);
        @(negedge clk);
        dat_evt_i = d; cmd_evt_i = c;
        @(negedge clk);
        dat_evt_i = '0; cmd_evt_i = '0;
    endtask

    task automatic edges(input int n);
        repeat (n) @(posedge clk);
        @(negedge clk);
    endtask

    task automatic t_reset;
        for (int a = 0; a < 8; a++) rd_check("R1 reset regs", 3'(a), 8'h00);
        check("R1 reset irq", {7'd0, irq_o}, 8'h00);
    endtask

    task automatic t_events;
        for (int b = 0; b < 8; b++) begin
            pulse(2'b00, 8'(1 << b));
            rd_check("R2 status1 accumulate", 3'd1, 8'((1 << (b + 1)) - 1));
        end
        pulse(2'b10, 8'h00);
        rd_check("R2 multi-block done bit4", 3'd0, 8'h10);
        pulse(2'b01, 8'h00);
        rd_check("R2 block done bit5", 3'd0, 8'h30);
    endtask

    task automatic t_w1c;
        wr(3'd1, 8'h00);
        rd_check("R3 write zero no effect", 3'd1, 8'hFF);
        wr(3'd1, 8'h0F);
        rd_check("R3 partial clear", 3'd1, 8'hF0);
        wr(3'd1, 8'hFF);
        rd_check("R3 full clear", 3'd1, 8'h00);
        wr(3'd0, 8'h20);
        rd_check("R3 status0 partial", 3'd0, 8'h10);
        wr(3'd0, 8'hFF);
        rd_check("R3 status0 full", 3'd0, 8'h00);
    endtask

    task automatic t_collide;
        pulse(2'b00, 8'h04);
        @(negedge clk);
        reg_addr_i = 3'd1; reg_wdata_i = 8'h04; reg_wr_i = 1'b1; cmd_evt_i = 8'h04;
        @(negedge clk);
        reg_wr_i = 1'b0; cmd_evt_i = 8'h00;
        rd_check("R4 same-bit event wins", 3'd1, 8'h04);
        @(negedge clk);
        reg_addr_i = 3'd1; reg_wdata_i = 8'h04; reg_wr_i = 1'b1; cmd_evt_i = 8'h08;
        @(negedge clk);
        reg_wr_i = 1'b0; cmd_evt_i = 8'h00;
        rd_check("R4 other-bit clear and set", 3'd1, 8'h08);
        wr(3'd1, 8'hFF);
    endtask

    task automatic t_masks;
        wr(3'd2, 8'hFF);
        rd_check("R5 enable0 writable bits", 3'd2, 8'hF0);
        wr(3'd3, 8'hFF);
        rd_check("R5 enable1 writable bits", 3'd3, 8'hFE);
        wr(3'd2, 8'h00);
        wr(3'd3, 8'h00);
        rd_check("R5 enable1 cleared", 3'd3, 8'h00);
    endtask

    task automatic t_irq;
        wr(3'd3, 8'h02);
        pulse(2'b00, 8'h02);
        check("R7 gie off", {7'd0, irq_o}, 8'h00);
        wr(3'd4, 8'h80);
        check("R6 gie on irq", {7'd0, irq_o}, 8'h01);
        wr(3'd1, 8'h02);
        check("R6 cleared irq", {7'd0, irq_o}, 8'h00);
        pulse(2'b00, 8'h10);
        check("R6 unmasked source", {7'd0, irq_o}, 8'h00);
        wr(3'd1, 8'hFF);
        wr(3'd3, 8'hFF);
        pulse(2'b00, 8'h01);
        rd_check("R6 sdio status set", 3'd1, 8'h01);
        check("R6 sdio no irq", {7'd0, irq_o}, 8'h00);
        wr(3'd1, 8'hFF);
        wr(3'd3, 8'h00);
    endtask

    task automatic t_cd;
        wr(3'd4, 8'hA0);
        wr(3'd2, 8'h80);
        wr(3'd0, 8'hFF);
        rd_check("R8 idle", 3'd0, 8'h00);
        @(negedge clk); cd_gpi_i = 1'b0;
        edges(2);
        rd_check("R8 not before third edge", 3'd0, 8'h08);
        edges(1);
        rd_check("R8 insert and change", 3'd0, 8'hC8);
        check("R8 insert irq", {7'd0, irq_o}, 8'h01);
        wr(3'd0, 8'hC0);
        rd_check("R8 cleared", 3'd0, 8'h08);
        check("R8 irq dropped", {7'd0, irq_o}, 8'h00);
        @(negedge clk); cd_gpi_i = 1'b1;
        edges(3);
        rd_check("R8 removal change only", 3'd0, 8'h40);
        wr(3'd0, 8'hFF);
        @(negedge clk); cd_dat3_i = 1'b0;
        edges(4);
        rd_check("R11 unselected dat3 ignored", 3'd0, 8'h04);
        @(negedge clk); cd_dat3_i = 1'b1;
        edges(4);
        rd_check("R11 unselected dat3 back", 3'd0, 8'h00);
        wr(3'd4, 8'hB0);
        edges(2);
        rd_check("R8 active-high polarity", 3'd0, 8'hCC);
        wr(3'd0, 8'hFF);
        rd_check("R9 live bits survive clear", 3'd0, 8'h0C);
        wr(3'd2, 8'h00);
    endtask

    task automatic t_wp;
        @(negedge clk); wp_i = 1'b1;
        edges(2);
        rd_check("R9 write protect level", 3'd0, 8'h0E);
        wr(3'd0, 8'h0E);
        rd_check("R9 live bits ignore write", 3'd0, 8'h0E);
    endtask

    task automatic t_srst;
        wr(3'd3, 8'hFE);
        wr(3'd2, 8'hF0);
        pulse(2'b11, 8'h20);
        @(negedge clk);
        reg_addr_i = 3'd5; reg_wdata_i = 8'h80; reg_wr_i = 1'b1; cmd_evt_i = 8'h40;
        @(negedge clk);
        reg_wr_i = 1'b0; cmd_evt_i = 8'h00;
        rd_check("R10 mode reads zero", 3'd5, 8'h00);
        rd_check("R10 status1 cleared", 3'd1, 8'h00);
        rd_check("R10 status0 sticky cleared", 3'd0, 8'h0E);
        rd_check("R10 enable0 cleared", 3'd2, 8'h00);
        rd_check("R10 enable1 cleared", 3'd3, 8'h00);
        rd_check("R10 config kept", 3'd4, 8'hB0);
        check("R10 irq low", {7'd0, irq_o}, 8'h00);
    endtask

    initial begin
        repeat (4) @(posedge clk);
        @(negedge clk); rst_n = 1'b1;
        edges(3);
        t_reset;
        t_events;
        t_w1c;
        t_collide;
        t_masks;
        t_irq;
        t_cd;
        t_wp;
        t_srst;
        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (50000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end
endmodule